// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Split Masking

This block decides which of several masters owns a shared on-chip bus. Each master raises its own request line and receives its own grant line. The arbiter watches the transfer type on the bus, the ready strobe, a shared lock flag and the two-bit slave response. From these it keeps a registered one-hot grant vector and the index of the owning master. Ownership is decided by fixed priority, with master 0 the most important. When nobody is eligible, the bus is parked on a default master.

The choice of the next owner is made while the current transfer is still running. The new grant appears right after the clock edge that sampled the inputs, so a handover costs no idle cycle. Handover is allowed only at transfer boundaries, and the lock flag keeps the current owner in place.

A retry response makes the arbiter choose again under the normal order, so only a more important requester can displace the retrying master. A split response records the owner in a per-master mask and removes it from the contest until a per-master resume pulse arrives. While it is masked, less important masters can win the bus.

Top module: `bus_prio_arbiter`

## Requirements
- R1: After reset the owner index is 0, the grant vector is 0001 and every split mask bit is clear. At every later cycle the grant vector has exactly one bit set, and that bit is the one at the owner index.
- R2: On a cycle where ownership may move, the owner after the next clock edge is the lowest-index master whose request is high and whose split mask bit (as updated that cycle) is clear.
- R3: If ownership may move and no master is eligible, the owner after the next edge is the default master, index 0.
- R4: With response OKAY (00) or ERROR (01), ownership may move only on a cycle where ready is high, lock is low and the transfer type is IDLE (00) or NONSEQUENTIAL (10). BUSY (01), SEQUENTIAL (11) or ready low keep the owner.
- R5: While lock is high and the response is OKAY or ERROR, the owner does not change, whatever the requests are.
- R6: A RETRY response (10) makes ownership movable that cycle, regardless of lock, ready and transfer type. The mask is left untouched, so the retrying master stays eligible at its normal priority.
- R7: A SPLIT response (11) sets the mask bit of the current owner and makes ownership movable that cycle, regardless of lock, ready and transfer type. The split master is excluded from that same choice.
- R8: A pulse on resume input i clears mask bit i, and master i is eligible again from that cycle on. If a split of owner i arrives in the same cycle, the split wins and the bit stays set.
- R9: An ERROR response neither sets a mask bit nor forces a handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_MASTERS | Per-master bus request |
| trans_i | input | 2 | Current transfer type: 00 IDLE, 01 BUSY, 10 NONSEQUENTIAL, 11 SEQUENTIAL |
| ready_i | input | 1 | Current transfer completes this cycle |
| lock_i | input | 1 | Shared lock: current and following transfer are indivisible |
| resp_i | input | 2 | Slave response: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| unsplit_i | input | NUM_MASTERS | Per-master resume pulse clearing the split mask bit |
| grant_o | output | NUM_MASTERS | One-hot registered grant |
| owner_o | output | IDX_W | Index of the master owning the bus |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it: ownership, grant and mask all update at the edge that samples the request, transfer, lock, ready, response and resume inputs. The bench drives inputs just after a falling edge. A behavioural reference updates at the rising edge, and both outputs are compared at the next falling edge. Mask effects are therefore observed through the owner that the next movable cycle selects. Directed sequences put split, resume, retry, lock and burst-hold cases at known cycles, and a long randomised run follows them.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        RS_OKAY  = 2'b00,
        RS_ERROR = 2'b01,
        RS_RETRY = 2'b10,
        RS_SPLIT = 2'b11
    } resp_e;

    // Responses that end the current owner's tenure for this cycle
    function automatic logic resp_forces(resp_e r);
        return (r == RS_RETRY) || (r == RS_SPLIT);
    endfunction

    // Transfer types at which a new owner may take over
    function automatic logic trans_boundary(trans_e t);
        return (t == TR_IDLE) || (t == TR_NONSEQ);
    endfunction

endpackage

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
    parameter int NUM_MASTERS = 4,
    parameter int IDX_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [IDX_W-1:0]       owner_i,
    input  logic                   split_i,
    input  logic [NUM_MASTERS-1:0] unsplit_i,
    output logic [NUM_MASTERS-1:0] mask_next_o
);

    logic [NUM_MASTERS-1:0] mask_q;

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_bit
        // A new split of this master takes precedence over its resume pulse
        assign mask_next_o[g] = (split_i && (owner_i == IDX_W'(g)))
                              | (mask_q[g] & ~unsplit_i[g]);

        AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (unsplit_i[g] && !(split_i && owner_i == IDX_W'(g))) |=> !mask_q[g]); // R8
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_next_o;
    end

    AST_SPLIT_SETS: assert property (@(posedge clk) disable iff (rst)
        split_i |=> mask_q[$past(owner_i)]); // R7

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int NUM_MASTERS = 4,
    parameter int IDX_W       = 2
) (
    input  logic [NUM_MASTERS-1:0] eligible_i,
    output logic                   any_o,
    output logic [IDX_W-1:0]       idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        // Scan from least to most important so the lowest index wins
        for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
            if (eligible_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/arb_owner_reg.sv
module arb_owner_reg #(
    parameter int NUM_MASTERS = 4,
    parameter int IDX_W       = 2,
    parameter int DEFAULT_IDX = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   move_i,
    input  logic [IDX_W-1:0]       next_idx_i,
    output logic [IDX_W-1:0]       owner_o,
    output logic [NUM_MASTERS-1:0] grant_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_o <= IDX_W'(DEFAULT_IDX);
            grant_o <= NUM_MASTERS'(1) << DEFAULT_IDX;
        end else if (move_i) begin
            owner_o <= next_idx_i;
            grant_o <= NUM_MASTERS'(1) << next_idx_i;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        ($countones(grant_o) == 1) && grant_o[owner_o]); // R1

endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int DEFAULT_IDX = 0,
    parameter int IDX_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [1:0]             trans_i,
    input  logic                   ready_i,
    input  logic                   lock_i,
    input  logic [1:0]             resp_i,
    input  logic [NUM_MASTERS-1:0] unsplit_i,
    output logic [NUM_MASTERS-1:0] grant_o,
    output logic [IDX_W-1:0]       owner_o
);

    trans_e                 trans;
    resp_e                  resp;
    logic                   split_evt;
    logic                   forced;
    logic                   move;
    logic [NUM_MASTERS-1:0] mask_next;
    logic [NUM_MASTERS-1:0] eligible;
    logic                   pick_any;
    logic [IDX_W-1:0]       pick_idx;
    logic [IDX_W-1:0]       next_idx;

    assign trans     = trans_e'(trans_i);
    assign resp      = resp_e'(resp_i);
    assign split_evt = (resp == RS_SPLIT);
    assign forced    = resp_forces(resp);
    assign move      = forced || (!lock_i && ready_i && trans_boundary(trans));
    assign eligible  = req_i & ~mask_next;
    assign next_idx  = pick_any ? pick_idx : IDX_W'(DEFAULT_IDX);

    arb_split_mask #(.NUM_MASTERS(NUM_MASTERS), .IDX_W(IDX_W)) u_mask (
        .clk         (clk),
        .rst         (rst),
        .owner_i     (owner_o),
        .split_i     (split_evt),
        .unsplit_i   (unsplit_i),
        .mask_next_o (mask_next)
    );

    arb_prio_pick #(.NUM_MASTERS(NUM_MASTERS), .IDX_W(IDX_W)) u_pick (
        .eligible_i (eligible),
        .any_o      (pick_any),
        .idx_o      (pick_idx)
    );

    arb_owner_reg #(
        .NUM_MASTERS (NUM_MASTERS),
        .IDX_W       (IDX_W),
        .DEFAULT_IDX (DEFAULT_IDX)
    ) u_owner (
        .clk        (clk),
        .rst        (rst),
        .move_i     (move),
        .next_idx_i (next_idx),
        .owner_o    (owner_o),
        .grant_o    (grant_o)
    );

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (lock_i && !resp_i[1]) |=> $stable(owner_o)); // R5

    AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ((trans_i == 2'b01 || trans_i == 2'b11 || !ready_i) && !resp_i[1])
        |=> $stable(grant_o)); // R4

    AST_ERROR_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (resp_i == 2'b01 && (lock_i || !ready_i)) |=> $stable(owner_o)); // R9

endmodule

// File: tb/test_bus_prio_arbiter.sv
`timescale 1ns/1ps
module test_bus_prio_arbiter;

    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic [1:0]    trans = 2'b00;
    logic          ready = 1'b1;
    logic          lock = 1'b0;
    logic [1:0]    resp = 2'b00;
    logic [N-1:0]  unsplit = '0;
    logic [N-1:0]  grant;
    logic [IW-1:0] owner;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state
    int       m_owner = 0;
    bit [N-1:0] m_mask = '0;
    string    m_why = "R1 reset";

    always #4 clk = ~clk;

    bus_prio_arbiter #(.NUM_MASTERS(N)) i_bus_prio_arbiter (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .trans_i   (trans),
        .ready_i   (ready),
        .lock_i    (lock),
        .resp_i    (resp),
        .unsplit_i (unsplit),
        .grant_o   (grant),
        .owner_o   (owner)
    );

    // Behavioural reference, updated on the same edge as the design
    always @(posedge clk) begin
        bit [N-1:0] nm;
        bit         mv;
        int         pick;
        bit         resumed;
        if (rst) begin
            m_owner = 0;
            m_mask  = '0;
            m_why   = "R1 reset";
        end else begin
            resumed = (unsplit & m_mask) != 0;
            nm = m_mask & ~unsplit;
            if (resp == 2'b11) nm[m_owner] = 1'b1;
            mv = (resp == 2'b10) || (resp == 2'b11) ||
                 (!lock && ready && (trans == 2'b00 || trans == 2'b10));
            pick = -1;
            for (int i = N - 1; i >= 0; i--)
                if (req[i] && !nm[i]) pick = i;
            if (resp == 2'b11)      m_why = "R7 split";
            else if (resp == 2'b10) m_why = "R6 retry";
            else if (mv && resumed) m_why = "R8 resume";
            else if (mv && pick < 0) m_why = "R3 default";
            else if (mv)            m_why = "R2 priority";
            else if (resp == 2'b01) m_why = "R9 error ignored";
            else if (lock)          m_why = "R5 lock";
            else                    m_why = "R4 burst hold";
            if (mv) m_owner = (pick < 0) ? 0 : pick;
            m_mask = nm;
        end
    end

    task automatic check_outputs();
        bit [N-1:0] exp_g;
        exp_g = N'(1) << m_owner;
        checks++;
        if (int'(owner) != m_owner) begin
            errors++;
            $display("FAIL %s owner actual=%0d expected=%0d", m_why, owner, m_owner);
        end
        checks++;
        if (grant !== exp_g) begin
            errors++;
            $display("FAIL R1 grant (%s) actual=%b expected=%b", m_why, grant, exp_g);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic [1:0] t, input logic rd,
                        input logic lk, input logic [1:0] rs, input logic [N-1:0] us);
        req = r; trans = t; ready = rd; lock = lk; resp = rs; unsplit = us;
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_outputs();                                 // R1 reset state
        rst = 1'b0;
        // R2: lowest-index requester wins on NONSEQ
        step(4'b1010, 2'b10, 1, 0, 2'b00, 4'b0000);      // owner 1
        // R3: nobody requests -> default 0
        step(4'b0000, 2'b00, 1, 0, 2'b00, 4'b0000);
        step(4'b0100, 2'b10, 1, 0, 2'b00, 4'b0000);      // owner 2
        // R4: SEQ, BUSY and ready low hold owner 2
        step(4'b0001, 2'b11, 1, 0, 2'b00, 4'b0000);
        step(4'b0001, 2'b01, 1, 0, 2'b00, 4'b0000);
        step(4'b0001, 2'b10, 0, 0, 2'b00, 4'b0000);
        // R5: lock holds against a higher-priority request
        step(4'b0001, 2'b10, 1, 1, 2'b00, 4'b0000);
        step(4'b0001, 2'b00, 1, 1, 2'b00, 4'b0000);
        // R9: error during lock does not move
        step(4'b0001, 2'b10, 1, 1, 2'b01, 4'b0000);
        // R6: retry under lock with only owner 2 requesting keeps 2
        step(4'b0100, 2'b11, 0, 1, 2'b10, 4'b0000);
        // R6: retry with a more important requester hands over to 1
        step(4'b0110, 2'b11, 0, 0, 2'b10, 4'b0000);      // owner 1
        // R7: split of owner 1 lets lower master 3 in
        step(4'b1010, 2'b11, 0, 1, 2'b11, 4'b0000);      // owner 3
        // R7: master 1 stays excluded while masked
        step(4'b1010, 2'b10, 1, 0, 2'b00, 4'b0000);      // still 3
        // R3: only masked master requests -> default 0
        step(4'b0010, 2'b00, 1, 0, 2'b00, 4'b0000);
        // R8: split and resume together on owner 0; split wins
        step(4'b0011, 2'b10, 1, 0, 2'b11, 4'b0001);      // 0 masked, 1 masked -> default 0
        step(4'b0011, 2'b10, 1, 0, 2'b00, 4'b0000);      // still default 0
        // R8: resume master 1 -> it wins at once
        step(4'b0011, 2'b10, 1, 0, 2'b00, 4'b0010);      // owner 1
        step(4'b0011, 2'b10, 1, 0, 2'b00, 4'b0001);      // owner 0
        // Randomised run
        for (int c = 0; c < 4000; c++) begin
            logic [1:0]   rs;
            logic [N-1:0] us;
            int           p;
            p  = $urandom_range(0, 99);
            rs = (p < 6) ? 2'b11 : (p < 12) ? 2'b10 : (p < 18) ? 2'b01 : 2'b00;
            for (int b = 0; b < N; b++) us[b] = ($urandom_range(0, 9) == 0);
            step(N'($urandom), 2'($urandom), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 4) == 0, rs, us);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule